// File: doc/BRIEF.md
# Multiply-Add High Doubleword Unit

This unit multiplies two 64-bit integers to the full 128-bit product and adds a third 64-bit operand. It returns only the upper 64 bits of the 128-bit sum. A single mode bit picks the form. In the signed form the two factors are two's-complement and the addend is sign-extended. In the unsigned form all three operands are unsigned and the addend is zero-extended. The addend enters below bit 64, so it reaches the returned word only through its extension and through the carry out of the low half.

The unit takes one operation at a time. An operation is accepted on a clock edge where `in_valid` and `ready` are both high. The multiplier then consumes the B operand in `STEPS` slices and adds one partial product per cycle. The final add places the result on `result_hi` with a one-cycle `out_valid` pulse, exactly `STEPS` cycles after acceptance (4 by default). The unit is used wherever a wide integer pipeline needs the high word of a fused multiply-add without widening its register file.

Top module: `madd_hi_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `out_valid` = 0 and `ready` = 1.
- R2: While `ready` is low, `in_valid` and the operand inputs are ignored. The result of the operation in flight does not change, and no extra `out_valid` pulse appears.
- R3: An operation accepted at clock edge k raises `out_valid` for exactly one cycle after edge k+4 (k+STEPS). `out_valid` stays low for the cycles after edges k+1 through k+3. `ready` is low after edges k through k+3 and high again in the cycle where `out_valid` is high.
- R4: With `mode` = 1 (unsigned), `result_hi` equals bits 127:64 of A×B + C. A, B and C are read as unsigned, and C is zero-extended to 128 bits.
- R5: With `mode` = 0 (signed), `result_hi` equals bits 127:64 of A×B + C. A and B are read as two's-complement, and C is sign-extended to 128 bits: its upper half is all ones when C is negative and all zeros otherwise.
- R6: A carry out of the low 64 bits of the sum reaches the returned word. For example, unsigned A = all ones, B = 1, C = 1 returns 1.
- R7: `result_hi` holds its value after the `out_valid` pulse until the next result is delivered.
- R8: Signed corner cases are exact. The most negative value squared with C = 0 returns 64'h4000_0000_0000_0000. A = −1, B = 1, C = most negative returns all ones. A = −1, B = −1, C = most negative returns all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation request |
| mode | input | 1 | 1 = unsigned form, 0 = signed form |
| a | input | 64 | First factor |
| b | input | 64 | Second factor |
| c | input | 64 | Addend |
| ready | output | 1 | Unit idle, can accept a request |
| out_valid | output | 1 | One-cycle strobe: `result_hi` is new |
| result_hi | output | 64 | Upper 64 bits of A×B + C |

## Verification
The bench sweeps every pairing of boundary factors (0, 1, 2, −1, most negative, most positive, a 32-bit all-ones value and a mixed pattern) against several addends in both modes, and adds random operands. Each result is compared with a 128-bit arithmetic model. The sweep targets the following faults:
- A design that zero-extends the factors in signed mode, or sign-extends C in unsigned mode, misses by exactly the factor or by all ones.
- A design that drops the low-half carry returns one less whenever the addend overflows the low word. The carry case is also checked by name.
- A sign extension off by one bit gets the most-negative squared case wrong.

During the cycles an operation is busy, the bench drives a different request and checks that the latency, the single pulse and the result are unaffected.

// File: rtl/madd_pkg.sv
// Package: shared encodings for the multiply-add high unit.
// Assumes: mode is a single bit; 1 selects the unsigned form.
package madd_pkg;
    typedef enum logic {
        MODE_SIGNED   = 1'b0,
        MODE_UNSIGNED = 1'b1
    } madd_mode_e;
endpackage

// File: rtl/madd_ctrl.sv
// Module: madd_ctrl
// Sequences one operation: accept, STEPS-1 accumulation cycles, then finish.
// Assumes STEPS >= 2. Produces the one-cycle out_valid strobe.
module madd_ctrl #(
    parameter int unsigned STEPS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      ready,
    output logic                      accept,
    output logic                      step_en,
    output logic                      finish,
    output logic [$clog2(STEPS)-1:0]  step_sel,
    output logic                      out_valid
);
    localparam int unsigned CNTW = $clog2(STEPS + 1);
    localparam int unsigned SELW = $clog2(STEPS);

    logic            busy;
    logic [CNTW-1:0] cnt;

    // Handshake and phase decode from busy flag and slice counter.
    always_comb begin
        ready    = ~busy;
        accept   = in_valid & ~busy;
        step_en  = busy & (cnt < CNTW'(STEPS));
        finish   = busy & (cnt == CNTW'(STEPS));
        step_sel = cnt[SELW-1:0];
    end

    // Busy flag, slice counter and result strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            cnt       <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= finish;
            if (accept) begin
                busy <= 1'b1;
                cnt  <= CNTW'(1);
            end else if (step_en) begin
                cnt <= cnt + CNTW'(1);
            end else if (finish) begin
                busy <= 1'b0;
                cnt  <= '0;
            end
        end
    end

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    assert_pulse_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (ready && $past(!ready)));
    assert_accept_starts_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!ready && !out_valid));
endmodule

// File: rtl/madd_pp_step.sv
// Module: madd_pp_step
// One partial product: the extended A times one CHUNK-bit slice of the
// extended B, shifted to the slice position and truncated to 2*W bits.
// Assumes: the slices are unsigned pieces of a 2*W-bit two's-complement word.
module madd_pp_step #(
    parameter int unsigned W     = 64,
    parameter int unsigned STEPS = 4
) (
    input  logic [2*W-1:0]            a_ext,
    input  logic [2*W/STEPS-1:0]      slice,
    input  logic [$clog2(STEPS)-1:0]  sel,
    output logic [2*W-1:0]            pp
);
    localparam int unsigned DW    = 2 * W;
    localparam int unsigned CHUNK = DW / STEPS;

    logic [DW-1:0] prod;

    // Slice product, then shift it to its weight.
    always_comb begin
        prod = a_ext * {{(DW - CHUNK){1'b0}}, slice};
        pp   = prod << (CHUNK * int'(sel));
    end
endmodule

// File: rtl/madd_hi_add.sv
// Module: madd_hi_add
// Adds the extended addend to a 2*W-bit product and returns the upper W bits.
// The low half of the sum is reduced to its carry alone.
// Assumes mode follows madd_pkg encoding.
module madd_hi_add #(
    parameter int unsigned W = 64
) (
    input  logic [2*W-1:0] prod,
    input  logic [W-1:0]   c,
    input  logic           mode,
    output logic [W-1:0]   hi
);
    import madd_pkg::*;

    logic [W-1:0] c_upper;
    logic         carry;

    // Addend extension per mode, low-half carry, and upper-half add.
    always_comb begin
        c_upper = (mode == MODE_UNSIGNED) ? '0 : {W{c[W-1]}};
        carry   = prod[W-1:0] > ~c;
        hi      = prod[2*W-1:W] + c_upper + W'(carry);
    end
endmodule

// File: rtl/madd_hi_unit.sv
// Module: madd_hi_unit (top)
// Returns bits [2W-1:W] of A*B + C in signed or unsigned form.
// Latency is STEPS cycles from acceptance to out_valid. One operation is in
// flight at a time. Signed factors are sign-extended to 2W bits and the
// truncated 2W-bit product is formed from STEPS unsigned slices of B.
// Assumes: 2*W divisible by STEPS, STEPS >= 2.
module madd_hi_unit #(
    parameter int unsigned W     = 64,
    parameter int unsigned STEPS = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         mode,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic         ready,
    output logic         out_valid,
    output logic [W-1:0] result_hi
);
    import madd_pkg::*;

    localparam int unsigned DW    = 2 * W;
    localparam int unsigned CHUNK = DW / STEPS;
    localparam int unsigned SELW  = $clog2(STEPS);

    logic             accept, step_en, finish;
    logic [SELW-1:0]  step_sel;
    logic [DW-1:0]    a_ext_in, b_ext_in, a_ext_r, b_ext_r, acc_r, pp;
    logic [W-1:0]     c_r, hi_sum;
    logic             mode_r;
    logic [CHUNK-1:0] b_slices [STEPS];
    logic [DW-1:0]    pp_a;
    logic [CHUNK-1:0] pp_slice;
    logic [SELW-1:0]  pp_sel;

    madd_ctrl #(.STEPS(STEPS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ready(ready),
        .accept(accept), .step_en(step_en), .finish(finish),
        .step_sel(step_sel), .out_valid(out_valid)
    );

    // Extend the incoming factors to 2W bits per mode.
    always_comb begin
        a_ext_in = (mode == MODE_UNSIGNED) ? {{W{1'b0}}, a} : {{W{a[W-1]}}, a};
        b_ext_in = (mode == MODE_UNSIGNED) ? {{W{1'b0}}, b} : {{W{b[W-1]}}, b};
    end

    // Split the held B into its STEPS slices.
    for (genvar g = 0; g < STEPS; g++) begin : g_slice
        assign b_slices[g] = b_ext_r[g*CHUNK +: CHUNK];
    end

    // Feed the multiplier slice 0 of the new B on accept, else the held slice.
    always_comb begin
        pp_a     = accept ? a_ext_in : a_ext_r;
        pp_slice = accept ? b_ext_in[CHUNK-1:0] : b_slices[step_sel];
        pp_sel   = accept ? '0 : step_sel;
    end

    madd_pp_step #(.W(W), .STEPS(STEPS)) u_pp (
        .a_ext(pp_a), .slice(pp_slice), .sel(pp_sel), .pp(pp)
    );

    madd_hi_add #(.W(W)) u_add (
        .prod(acc_r), .c(c_r), .mode(mode_r), .hi(hi_sum)
    );

    // Operand capture, partial-product accumulation and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_ext_r   <= '0;
            b_ext_r   <= '0;
            c_r       <= '0;
            mode_r    <= 1'b0;
            acc_r     <= '0;
            result_hi <= '0;
        end else begin
            if (accept) begin
                a_ext_r <= a_ext_in;
                b_ext_r <= b_ext_in;
                c_r     <= c;
                mode_r  <= mode;
                acc_r   <= pp;
            end else if (step_en) begin
                acc_r <= acc_r + pp;
            end
            if (finish) begin
                result_hi <= hi_sum;
            end
        end
    end

    assert_operands_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ($stable(c_r) && $stable(mode_r) && $stable(a_ext_r) && $stable(b_ext_r)));
    assert_zero_a_unsigned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mode_r == MODE_UNSIGNED && a_ext_r == '0) |-> (result_hi == '0));
    assert_zero_a_signed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mode_r == MODE_SIGNED && a_ext_r == '0) |-> (result_hi == {W{c_r[W-1]}}));
    assert_result_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && $past(!out_valid)) |-> $stable(result_hi));
endmodule

// File: tb/madd_hi_unit_tb.sv
module madd_hi_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        mode = 1'b0;
    logic [63:0] a = '0, b = '0, c = '0;
    logic        ready, out_valid;
    logic [63:0] result_hi;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    localparam logic [63:0] MINV = 64'h8000_0000_0000_0000;
    localparam logic [63:0] MAXV = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    madd_hi_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .a(a), .b(b), .c(c), .ready(ready), .out_valid(out_valid),
        .result_hi(result_hi)
    );

    always #2 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests = n_tests + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // 128-bit arithmetic model.
    function automatic logic [63:0] model(input logic [63:0] x, input logic [63:0] y,
                                          input logic [63:0] z, input logic m);
        logic [127:0] s;
        if (m) begin
            s = {64'd0, x} * {64'd0, y} + {64'd0, z};
        end else begin
            logic signed [127:0] sp;
            sp = $signed(x);
            sp = sp * $signed(y);
            sp = sp + $signed(z);
            s = sp;
        end
        return s[127:64];
    endfunction

    task automatic run_op(input logic [63:0] x, input logic [63:0] y, input logic [63:0] z,
                          input logic m, input bit poke, input string req, input logic [63:0] exp);
        while (!ready) @(negedge clk);
        in_valid = 1'b1; a = x; b = y; c = z; mode = m;
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            if (poke && i <= 3) begin
                in_valid = 1'b1; a = ~x; b = y ^ 64'h5A5A; c = ~z; mode = ~m;
            end else begin
                in_valid = 1'b0;
            end
            chk(out_valid == 1'b0, "R3 early out_valid", {63'd0, out_valid}, 64'd0);
            if (i <= 3) chk(ready == 1'b0, "R2 ready while busy", {63'd0, ready}, 64'd0);
        end
        @(negedge clk);
        chk(out_valid == 1'b1, "R3 out_valid at latency", {63'd0, out_valid}, 64'd1);
        chk(ready == 1'b1, "R3 ready with result", {63'd0, ready}, 64'd1);
        chk(result_hi == exp, req, result_hi, exp);
        @(negedge clk);
        chk(out_valid == 1'b0, "R3 single pulse", {63'd0, out_valid}, 64'd0);
        chk(result_hi == exp, "R7 result held", result_hi, exp);
    endtask

    initial begin
        logic [63:0] edges [8];
        logic [63:0] adds [4];
        edges[0] = 64'd0; edges[1] = 64'd1; edges[2] = ONES; edges[3] = MINV;
        edges[4] = MAXV;  edges[5] = 64'd2; edges[6] = 64'h0000_0000_FFFF_FFFF;
        edges[7] = 64'h1234_5678_9ABC_DEF0;
        adds[0] = 64'd0; adds[1] = 64'd1; adds[2] = MINV; adds[3] = ONES;

        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 reset out_valid", {63'd0, out_valid}, 64'd0);
        chk(ready == 1'b1, "R1 reset ready", {63'd0, ready}, 64'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // Named corner cases
        run_op(ONES, 64'd1, 64'd1, 1'b1, 1'b0, "R6 low carry", 64'd1);
        run_op(MINV, MINV, 64'd0, 1'b0, 1'b0, "R8 min squared", 64'h4000_0000_0000_0000);
        run_op(ONES, 64'd1, MINV, 1'b0, 1'b0, "R8 -1*1+min", ONES);
        run_op(ONES, ONES, MINV, 1'b0, 1'b1, "R8 -1*-1+min", ONES);
        run_op(ONES, ONES, 64'd0, 1'b1, 1'b1, "R4 all ones squared", 64'hFFFF_FFFF_FFFF_FFFE);

        // Boundary sweep in both modes
        for (int m = 0; m < 2; m++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    for (int k = 0; k < 4; k++)
                        run_op(edges[i], edges[j], adds[k], m[0], ((i + j + k) % 2) == 1,
                               m == 1 ? "R4 unsigned sweep" : "R5 signed sweep",
                               model(edges[i], edges[j], adds[k], m[0]));

        // Random operands
        for (int r = 0; r < 200; r++) begin
            logic [63:0] x, y, z;
            x = {$urandom, $urandom}; y = {$urandom, $urandom}; z = {$urandom, $urandom};
            run_op(x, y, z, r[0], r[1], r[0] ? "R4 random" : "R5 random", model(x, y, z, r[0]));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule